// File: doc/BRIEF.md
# Two-Wire Serial Bus Master with Status Codes

This block is a register-mapped master for an open-drain two-wire serial bus (clock line and data line). Software moves it through a transfer one bus event at a time: it writes a command into the control register, the block performs exactly one bus action, and then it latches an 8-bit status code and raises an event flag. Possible actions are a start, a repeated start, one address or data byte out, one data byte in, or a stop.

After any event that leaves a transfer open, the block holds the clock line low. Nothing moves on the bus until software writes the control register again. A byte to send is placed in the data register before that control write. A received byte can be read from the same register once the event is flagged.

The bit rate comes from a two-field divider: (M+1)·2^N system clocks per tick, and ten ticks per bit. Each line is driven through a pull-low enable output. A write of any value to the soft-reset offset returns the whole block to idle.

Top module: `twowire_master`

## Requirements
- R1: After reset, and in the cycle after any write to offset 0x1C, the status reads 0xF8, the event flag and irq are 0, both pull-low enables are 0, and the address registers read 0.
- R2: Register map. Offset 0x00 is a read/write slave-address byte, 0x10 an extended-address byte and 0x04 the data byte. Offset 0x08 is control: bit 7 interrupt enable, bit 6 controller enable, bit 5 start, bit 4 stop, bit 3 event flag (read-only), bit 2 acknowledge enable. Bits 5 and 4 read back as 0. Offset 0x0C reads status and takes the baud value on write.
- R3: A start command issued from idle yields status 0x08 after 10 ticks. Issued while a transfer is held, it yields 0x10 after 10 ticks.
- R4: An address byte with bit 0 clear gives 0x18 if acknowledged and 0x20 if not, 90 ticks after the command.
- R5: A data byte sent after an address/data write event gives 0x28 if acknowledged and 0x30 if not. The byte reaches the slave MSB first.
- R6: An address byte with bit 0 set gives 0x40 if acknowledged and 0x48 if not.
- R7: After a 0x40/0x50/0x58 event, the next byte command receives a byte. The master drives ACK and reports 0x50 when control bit 2 is set, otherwise NACK and 0x58. The received byte is then in the data register.
- R8: A stop command from a held transfer returns status 0xF8 after 10 ticks, sets no event flag and releases both lines.
- R9: Each new code sets the event flag. While a transfer is held the clock line stays low and the flag stays set, and a data-register write starts no bus action.
- R10: If the master releases data during an address/data bit and samples it low, it reports 0x38 at that bit's sample point and releases both lines.
- R11: Baud write: M = bits 6..3, N = bits 2..0. One tick is (M+1)·2^N clocks.
- R12: irq equals the event flag AND control bit 7.
- R13: A control write with bit 6 clear starts no bus action.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational on reg_addr) |
| irq | output | 1 | Event flag gated by interrupt enable |
| scl_oe | output | 1 | Pull clock line low when 1 |
| sda_oe | output | 1 | Pull data line low when 1 |
| sda_in | input | 1 | Sensed level of the data line |

## Verification
With a divider of one clock per tick, each result lands on a fixed clock edge after the control-write edge: 10 edges for start, repeated start and stop, 90 for a byte, 8 for an arbitration loss on the first bit, and 1 for soft reset. The bench samples on falling edges and counts falling edges from the write edge to the first one where irq is high, then compares that count with the exact figure. For larger dividers the tick phase at the write is unknown, so the count is checked against a window one tick wide. For stop, which raises no flag, the status is read exactly 10 edges after the command.

// File: rtl/tws_pkg.sv
package tws_pkg;
    localparam int DW         = 8;
    localparam int REG_AW     = 5;
    localparam int BAUD_M_W   = 4;
    localparam int BAUD_N_W   = 3;
    localparam int PH_W       = 4;

    localparam logic [REG_AW-1:0] A_SLV  = 5'h00;
    localparam logic [REG_AW-1:0] A_DATA = 5'h04;
    localparam logic [REG_AW-1:0] A_CTRL = 5'h08;
    localparam logic [REG_AW-1:0] A_STAT = 5'h0C;
    localparam logic [REG_AW-1:0] A_EXT  = 5'h10;
    localparam logic [REG_AW-1:0] A_SRST = 5'h1C;

    localparam int C_ACK  = 2;
    localparam int C_FLAG = 3;
    localparam int C_STO  = 4;
    localparam int C_STA  = 5;
    localparam int C_EN   = 6;
    localparam int C_IE   = 7;

    // tick indices inside one bit slot (ten ticks per slot)
    localparam logic [PH_W-1:0] PH_EDGE_A = 4'd0;
    localparam logic [PH_W-1:0] PH_DRV    = 4'd2;
    localparam logic [PH_W-1:0] PH_EDGE_B = 4'd3;
    localparam logic [PH_W-1:0] PH_RISE   = 4'd5;
    localparam logic [PH_W-1:0] PH_EDGE_C = 4'd6;
    localparam logic [PH_W-1:0] PH_SAMP   = 4'd7;
    localparam logic [PH_W-1:0] PH_END    = 4'd9;
    localparam logic [PH_W-1:0] ACK_SLOT  = 4'(DW);

    typedef enum logic [DW-1:0] {
        ST_START  = 8'h08, ST_RSTART = 8'h10,
        ST_WA_ACK = 8'h18, ST_WA_NAK = 8'h20,
        ST_WD_ACK = 8'h28, ST_WD_NAK = 8'h30,
        ST_ARB    = 8'h38,
        ST_RA_ACK = 8'h40, ST_RA_NAK = 8'h48,
        ST_RD_ACK = 8'h50, ST_RD_NAK = 8'h58,
        ST_IDLE   = 8'hF8
    } stat_e;

    typedef enum logic [2:0] {E_IDLE, E_START, E_BIT, E_STOP, E_HOLD} eng_e;

    typedef struct packed {
        logic go;
        logic en;
        logic sta;
        logic sto;
        logic ack;
    } cmd_t;

    function automatic stat_e byte_status(logic is_addr, logic dir_rd, logic tx,
                                          logic got_ack, logic ack_en);
        if (is_addr)
            return dir_rd ? (got_ack ? ST_RA_ACK : ST_RA_NAK)
                          : (got_ack ? ST_WA_ACK : ST_WA_NAK);
        else if (tx)
            return got_ack ? ST_WD_ACK : ST_WD_NAK;
        else
            return ack_en ? ST_RD_ACK : ST_RD_NAK;
    endfunction
endpackage

// File: rtl/tws_baud_div.sv
module tws_baud_div #(
    parameter int M_W = 4,
    parameter int N_W = 3
) (
    input  logic           clk,
    input  logic           srst,
    input  logic [M_W-1:0] m,
    input  logic [N_W-1:0] n,
    output logic           tick
);
    localparam int CNT_W = M_W + (1 << N_W);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign lim  = ({{(CNT_W-M_W){1'b0}}, m} + CNT_W'(1)) << n;
    assign tick = (cnt >= lim - CNT_W'(1));

    always_ff @(posedge clk) begin
        if (srst)      cnt <= '0;
        else if (tick) cnt <= '0;
        else           cnt <= cnt + CNT_W'(1);
    end

    // R11: the counter never runs past the divider limit once settled
    p_cnt_bound_r11: assert property (@(posedge clk) disable iff (srst)
        ($stable(lim) && !$past(tick)) |-> (cnt <= lim));
endmodule

// File: rtl/tws_bus_engine.sv
module tws_bus_engine
    import tws_pkg::*;
(
    input  logic          clk,
    input  logic          srst,
    input  logic          tick,
    input  cmd_t          cmd,
    input  logic          data_we,
    input  logic [DW-1:0] data_wd,
    input  logic          sda_in,
    output logic          scl_lo,
    output logic          sda_lo,
    output logic [DW-1:0] data_q,
    output stat_e         status_q,
    output logic          flag_q
);
    eng_e            st;
    logic [PH_W-1:0] ph;
    logic [PH_W-1:0] bcnt;
    logic            rep, tx, is_addr, ack_en, got_ack;
    logic [DW-1:0]   shreg;
    logic            can_cmd;

    assign data_q  = shreg;
    assign can_cmd = (st == E_IDLE) || (st == E_HOLD);

    always_ff @(posedge clk) begin
        if (srst) begin
            st <= E_IDLE; ph <= '0; bcnt <= '0;
            scl_lo <= 1'b0; sda_lo <= 1'b0;
            shreg <= '0; status_q <= ST_IDLE; flag_q <= 1'b0;
            rep <= 1'b0; tx <= 1'b0; is_addr <= 1'b0;
            ack_en <= 1'b0; got_ack <= 1'b0;
        end else begin
            if (data_we && can_cmd) shreg <= data_wd;
            if (cmd.go && can_cmd) begin
                flag_q <= 1'b0;
                ph     <= '0;
                bcnt   <= '0;
                if (cmd.en) begin
                    if (cmd.sta) begin
                        st  <= E_START;
                        rep <= (st == E_HOLD);
                    end else if (st == E_HOLD) begin
                        if (cmd.sto) st <= E_STOP;
                        else begin
                            st      <= E_BIT;
                            is_addr <= status_q inside {ST_START, ST_RSTART};
                            tx      <= !(status_q inside {ST_RA_ACK, ST_RD_ACK, ST_RD_NAK});
                            ack_en  <= cmd.ack;
                        end
                    end
                end
            end else if (tick) begin
                case (st)
                    E_START, E_STOP: begin
                        ph <= ph + 4'd1;
                        if (ph == PH_EDGE_A) sda_lo <= (st == E_STOP);
                        if (ph == PH_EDGE_B) scl_lo <= 1'b0;
                        if (ph == PH_EDGE_C) sda_lo <= (st == E_START);
                        if (ph == PH_END) begin
                            ph <= '0;
                            if (st == E_START) begin
                                scl_lo   <= 1'b1;
                                st       <= E_HOLD;
                                status_q <= rep ? ST_RSTART : ST_START;
                                flag_q   <= 1'b1;
                            end else begin
                                st       <= E_IDLE;
                                status_q <= ST_IDLE;
                            end
                        end
                    end
                    E_BIT: begin
                        ph <= ph + 4'd1;
                        if (ph == PH_DRV) begin
                            if (bcnt != ACK_SLOT) sda_lo <= tx ? ~shreg[DW-1] : 1'b0;
                            else                  sda_lo <= tx ? 1'b0 : ack_en;
                        end
                        if (ph == PH_RISE) scl_lo <= 1'b0;
                        if (ph == PH_SAMP) begin
                            if (bcnt != ACK_SLOT) begin
                                shreg <= {shreg[DW-2:0], sda_in};
                                if (tx && !sda_lo && !sda_in) begin
                                    st       <= E_IDLE;
                                    ph       <= '0;
                                    scl_lo   <= 1'b0;
                                    sda_lo   <= 1'b0;
                                    status_q <= ST_ARB;
                                    flag_q   <= 1'b1;
                                end
                            end else begin
                                got_ack <= !sda_in;
                            end
                        end
                        if (ph == PH_END) begin
                            ph     <= '0;
                            scl_lo <= 1'b1;
                            if (bcnt == ACK_SLOT) begin
                                st       <= E_HOLD;
                                flag_q   <= 1'b1;
                                status_q <= byte_status(is_addr, shreg[0], tx, got_ack, ack_en);
                            end else begin
                                bcnt <= bcnt + 4'd1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R9: clock line is pulled low for as long as a transfer is held
    p_hold_scl_r9: assert property (@(posedge clk) disable iff (srst)
        (st == E_HOLD) |-> scl_lo);
    // R9: a raised flag always comes with a real event code
    p_flag_code_r9: assert property (@(posedge clk) disable iff (srst)
        $rose(flag_q) |-> (status_q != ST_IDLE));
    // R5: data line does not move while the clock is high inside a byte
    p_sda_stable_r5: assert property (@(posedge clk) disable iff (srst)
        (st == E_BIT && !scl_lo) |=> (st != E_BIT || $stable(sda_lo)));
    // R10: after losing arbitration both lines stay released
    p_arb_release_r10: assert property (@(posedge clk) disable iff (srst)
        (status_q == ST_ARB && flag_q) |-> (!scl_lo && !sda_lo));
    // R8: a stop never raises the event flag
    p_stop_noflag_r8: assert property (@(posedge clk) disable iff (srst)
        (st == E_STOP) |=> !flag_q);
endmodule

// File: rtl/twowire_master.sv
module twowire_master
    import tws_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    output logic              irq,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              sda_in
);
    localparam int BAUD_W = BAUD_M_W + BAUD_N_W;

    logic                srst;
    logic [DW-1:0]       slv_q, ext_q;
    logic [BAUD_W-1:0]   baud_q;
    logic                ie_q, en_q, ack_q;
    logic                tick;
    cmd_t                cmd;
    logic [DW-1:0]       data_q;
    stat_e               status;
    logic                flag;

    assign srst = rst || (reg_wr && reg_addr == A_SRST);

    always_ff @(posedge clk) begin
        if (srst) begin
            slv_q <= '0; ext_q <= '0; baud_q <= '0;
            ie_q <= 1'b0; en_q <= 1'b0; ack_q <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_SLV:  slv_q  <= reg_wdata;
                A_EXT:  ext_q  <= reg_wdata;
                A_STAT: baud_q <= reg_wdata[BAUD_W-1:0];
                A_CTRL: begin
                    ie_q  <= reg_wdata[C_IE];
                    en_q  <= reg_wdata[C_EN];
                    ack_q <= reg_wdata[C_ACK];
                end
                default: ;
            endcase
        end
    end

    assign cmd.go  = reg_wr && (reg_addr == A_CTRL);
    assign cmd.en  = reg_wdata[C_EN];
    assign cmd.sta = reg_wdata[C_STA];
    assign cmd.sto = reg_wdata[C_STO];
    assign cmd.ack = reg_wdata[C_ACK];

    tws_baud_div #(.M_W(BAUD_M_W), .N_W(BAUD_N_W)) u_div (
        .clk  (clk),
        .srst (srst),
        .m    (baud_q[BAUD_W-1:BAUD_N_W]),
        .n    (baud_q[BAUD_N_W-1:0]),
        .tick (tick)
    );

    tws_bus_engine u_eng (
        .clk      (clk),
        .srst     (srst),
        .tick     (tick),
        .cmd      (cmd),
        .data_we  (reg_wr && reg_addr == A_DATA),
        .data_wd  (reg_wdata),
        .sda_in   (sda_in),
        .scl_lo   (scl_oe),
        .sda_lo   (sda_oe),
        .data_q   (data_q),
        .status_q (status),
        .flag_q   (flag)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_SLV:  reg_rdata = slv_q;
            A_EXT:  reg_rdata = ext_q;
            A_DATA: reg_rdata = data_q;
            A_STAT: reg_rdata = status;
            A_CTRL: begin
                reg_rdata[C_IE]   = ie_q;
                reg_rdata[C_EN]   = en_q;
                reg_rdata[C_FLAG] = flag;
                reg_rdata[C_ACK]  = ack_q;
            end
            default: ;
        endcase
    end

    assign irq = flag && ie_q;

    // R1: a soft-reset write leaves the block idle on the next edge
    p_softreset_r1: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && reg_addr == A_SRST) |=> (status == ST_IDLE && !scl_oe && !sda_oe && !irq));
endmodule

// File: tb/test_twowire_master.sv
module test_twowire_master;
    import tws_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic reg_wr = 1'b0;
    logic [4:0] reg_addr = A_STAT;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic irq, scl_oe, sda_oe;
    logic scl_w, sda_w;
    logic slv_lo = 1'b0;
    logic jam = 1'b0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #10 clk = ~clk;   // 50 MHz

    assign scl_w = ~scl_oe;
    assign sda_w = ~(sda_oe | slv_lo | jam);

    twowire_master i_twowire_master (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_w)
    );

    // ---------------- behavioural slave at 7-bit address 0x50 ----------------
    localparam logic [6:0] SLV_ADDR = 7'h50;
    logic p_scl = 1'b1, p_sda = 1'b1;
    logic active = 1'b0, fresh = 1'b0, in_addr = 1'b0, addr_ok = 1'b0, rd = 1'b0, mack = 1'b0;
    int bitn = 0;
    logic [7:0] sh = '0;
    logic [7:0] txb = 8'h3C;
    logic [7:0] wlog0 = '0;
    int wcnt = 0;

    always @(scl_w, sda_w) begin
        if (scl_w && p_scl && !sda_w && p_sda) begin
            active = 1'b1; fresh = 1'b1; in_addr = 1'b1; bitn = 0; slv_lo = 1'b0;
        end else if (scl_w && p_scl && sda_w && !p_sda) begin
            active = 1'b0; slv_lo = 1'b0;
        end else if (scl_w && !p_scl && active) begin
            if (bitn < 8) sh = {sh[6:0], sda_w};
            else mack = !sda_w;
        end else if (!scl_w && p_scl && active) begin
            if (fresh) fresh = 1'b0;
            else if (bitn < 7) begin
                bitn++;
                if (rd && addr_ok && !in_addr) slv_lo = ~txb[7-bitn];
            end else if (bitn == 7) begin
                bitn = 8;
                if (in_addr) begin
                    addr_ok = (sh[7:1] == SLV_ADDR); rd = sh[0]; slv_lo = addr_ok;
                end else if (!rd) begin
                    if (addr_ok && wcnt == 0) wlog0 = sh;
                    if (addr_ok) wcnt++;
                    slv_lo = addr_ok && (sh != 8'hFF);
                end else slv_lo = 1'b0;
            end else begin
                bitn = 0; slv_lo = 1'b0;
                if (rd && addr_ok && (in_addr || mack)) begin
                    if (!in_addr) txb = txb + 8'd1;
                    slv_lo = ~txb[7];
                end
                in_addr = 1'b0;
            end
        end
        p_scl = scl_w; p_sda = sda_w;
    end

    // ---------------- helpers ----------------
    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cyc, 100000);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = A_STAT;
    endtask

    task automatic rd_reg(input logic [4:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
        reg_addr = A_STAT;
    endtask

    task automatic wait_evt(input int lo, input int hi, input logic [7:0] st, input string req);
        int n = 0;
        logic [7:0] s;
        while (!irq && n < 2000) begin
            @(negedge clk);
            n++;
        end
        chk(n >= lo && n <= hi, req, "event latency", n, lo);
        rd_reg(A_STAT, s);
        chk(s == st, req, "status", s, st);
    endtask

    // ---------------- vector table ----------------
    localparam int K_NONE = 0, K_EVT = 1, K_FIX = 2, K_SKIP = 3;
    typedef struct packed {
        logic [4:0] a;
        logic [7:0] wd;
        logic [1:0] kind;
        logic [7:0] lat;
        logic [7:0] st;
        logic       chkd;
        logic [7:0] d;
        logic [3:0] req;
    } vec_t;
    localparam int NV = 22;
    localparam vec_t VEC [NV] = '{
        '{A_CTRL, 8'hA0, 2'd0, 8'd0,  8'hF8, 1'b0, 8'h00, 4'd13}, // R13 start with enable clear
        '{A_CTRL, 8'hC0, 2'd0, 8'd0,  8'hF8, 1'b0, 8'h00, 4'd13}, // R13 enable only
        '{A_CTRL, 8'hE0, 2'd1, 8'd10, 8'h08, 1'b0, 8'h00, 4'd3},  // R3 start
        '{A_DATA, 8'hA0, 2'd3, 8'd0,  8'h00, 1'b0, 8'h00, 4'd4},
        '{A_CTRL, 8'hC0, 2'd1, 8'd90, 8'h18, 1'b0, 8'h00, 4'd4},  // R4 addr write ack
        '{A_DATA, 8'h12, 2'd3, 8'd0,  8'h00, 1'b0, 8'h00, 4'd5},
        '{A_CTRL, 8'hC0, 2'd1, 8'd90, 8'h28, 1'b0, 8'h00, 4'd5},  // R5 data ack
        '{A_DATA, 8'hFF, 2'd3, 8'd0,  8'h00, 1'b0, 8'h00, 4'd5},
        '{A_CTRL, 8'hC0, 2'd1, 8'd90, 8'h30, 1'b0, 8'h00, 4'd5},  // R5 data nack
        '{A_CTRL, 8'hE0, 2'd1, 8'd10, 8'h10, 1'b0, 8'h00, 4'd3},  // R3 repeated start
        '{A_DATA, 8'hA1, 2'd3, 8'd0,  8'h00, 1'b0, 8'h00, 4'd6},
        '{A_CTRL, 8'hC0, 2'd1, 8'd90, 8'h40, 1'b0, 8'h00, 4'd6},  // R6 addr read ack
        '{A_CTRL, 8'hC4, 2'd1, 8'd90, 8'h50, 1'b1, 8'h3C, 4'd7},  // R7 receive with ACK
        '{A_CTRL, 8'hC0, 2'd1, 8'd90, 8'h58, 1'b1, 8'h3D, 4'd7},  // R7 receive with NACK
        '{A_CTRL, 8'hD0, 2'd2, 8'd10, 8'hF8, 1'b0, 8'h00, 4'd8},  // R8 stop
        '{A_CTRL, 8'hE0, 2'd1, 8'd10, 8'h08, 1'b0, 8'h00, 4'd3},
        '{A_DATA, 8'hB0, 2'd3, 8'd0,  8'h00, 1'b0, 8'h00, 4'd4},
        '{A_CTRL, 8'hC0, 2'd1, 8'd90, 8'h20, 1'b0, 8'h00, 4'd4},  // R4 addr write nack
        '{A_CTRL, 8'hE0, 2'd1, 8'd10, 8'h10, 1'b0, 8'h00, 4'd3},
        '{A_DATA, 8'hB1, 2'd3, 8'd0,  8'h00, 1'b0, 8'h00, 4'd6},
        '{A_CTRL, 8'hC0, 2'd1, 8'd90, 8'h48, 1'b0, 8'h00, 4'd6},  // R6 addr read nack
        '{A_CTRL, 8'hD0, 2'd2, 8'd10, 8'hF8, 1'b0, 8'h00, 4'd8}   // R8 stop
    };

    initial begin
        logic [7:0] v;
        string tag;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_reg(A_STAT, v); chk(v == 8'hF8, "R1", "reset status", v, 8'hF8);
        chk(!irq && !scl_oe && !sda_oe, "R1", "reset outputs", {irq, scl_oe, sda_oe}, 0);
        rd_reg(A_SLV, v);  chk(v == 8'h00, "R1", "reset slave addr", v, 0);

        // R2 register readback
        wr(A_SLV, 8'h5A); wr(A_EXT, 8'h33);
        rd_reg(A_SLV, v); chk(v == 8'h5A, "R2", "slave addr reg", v, 8'h5A);
        rd_reg(A_EXT, v); chk(v == 8'h33, "R2", "ext addr reg", v, 8'h33);
        wr(A_STAT, 8'h00); // R11 unit divider

        for (int i = 0; i < NV; i++) begin
            tag = $sformatf("R%0d", VEC[i].req);
            wr(VEC[i].a, VEC[i].wd);
            case (int'(VEC[i].kind))
                K_NONE: begin
                    repeat (20) @(negedge clk);
                    rd_reg(A_STAT, v);
                    chk(v == VEC[i].st && !irq && !scl_oe, tag, "no action", v, VEC[i].st);
                end
                K_EVT: begin
                    wait_evt(VEC[i].lat, VEC[i].lat, VEC[i].st, tag);
                    if (VEC[i].chkd) begin
                        rd_reg(A_DATA, v); chk(v == VEC[i].d, tag, "received byte", v, VEC[i].d);
                        chk(mack == (VEC[i].st == 8'h50), tag, "master ack driven", mack, VEC[i].st == 8'h50);
                    end
                end
                K_FIX: begin
                    repeat (VEC[i].lat) @(negedge clk);
                    rd_reg(A_STAT, v);
                    chk(v == VEC[i].st && !irq && !scl_oe && !sda_oe, tag, "stop result", v, VEC[i].st);
                end
                default: ;
            endcase
        end
        chk(wlog0 == 8'h12, "R5", "byte seen by slave", wlog0, 8'h12);

        // R9 hold: data write while held does nothing, clock stays low
        wr(A_CTRL, 8'hE0); wait_evt(10, 10, 8'h08, "R9");
        wr(A_DATA, 8'hA0);
        repeat (40) @(negedge clk);
        rd_reg(A_STAT, v);
        chk(v == 8'h08 && irq && scl_oe, "R9", "held after data write", v, 8'h08);
        rd_reg(A_CTRL, v); chk(v == 8'hC8, "R2", "control readback", v, 8'hC8);

        // R1 soft reset while held
        wr(A_SLV, 8'h77);
        wr(A_SRST, 8'h00);
        rd_reg(A_STAT, v);
        chk(v == 8'hF8 && !irq && !scl_oe && !sda_oe, "R1", "soft reset", v, 8'hF8);
        rd_reg(A_SLV, v); chk(v == 8'h00, "R1", "soft reset slave addr", v, 0);

        // R12 flag without interrupt enable
        wr(A_CTRL, 8'h60);
        repeat (15) @(negedge clk);
        rd_reg(A_CTRL, v);
        chk(!irq && v == 8'h48, "R12", "irq masked, flag set", {irq, v}, 8'h48);
        wr(A_CTRL, 8'hD0); repeat (12) @(negedge clk);

        // R10 arbitration loss on first address bit
        wr(A_CTRL, 8'hE0); wait_evt(10, 10, 8'h08, "R10");
        jam = 1'b1;
        wr(A_DATA, 8'hA0);
        wr(A_CTRL, 8'hC0); wait_evt(8, 8, 8'h38, "R10");
        chk(!scl_oe && !sda_oe, "R10", "lines released", {scl_oe, sda_oe}, 0);
        jam = 1'b0;
        repeat (4) @(negedge clk);

        // R11 divider scaling
        wr(A_STAT, 8'h08);                      // M=1 N=0 -> 2 clocks per tick
        wr(A_CTRL, 8'hE0); wait_evt(19, 20, 8'h08, "R11");
        wr(A_STAT, 8'h0A);                      // M=1 N=2 -> 8 clocks per tick
        wr(A_DATA, 8'hA0);
        wr(A_CTRL, 8'hC0); wait_evt(713, 720, 8'h18, "R11");
        wr(A_STAT, 8'h00);
        wr(A_CTRL, 8'hD0); repeat (12) @(negedge clk);
        rd_reg(A_STAT, v); chk(v == 8'hF8, "R8", "final stop", v, 8'hF8);

        summary();
        $finish;
    end
endmodule